// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

A single-channel data mover. A one-cycle `start` pulse latches a configuration word, a block length, source and destination base addresses, a priority level and the acknowledge settings. After that, each peripheral request pulse on `req` triggers one transfer unit. A unit is a run of beats. Each beat reads from the source pointer and then writes the returned data to the destination pointer. Each pointer is kept fixed, stepped up or stepped down by its own step size after every beat.

The trigger mode sets how much one request moves:
- a short buffer of 1 to 128 bytes;
- the whole block, once;
- the whole block, over and over, with the pointers and the byte count restored after each block.

Each completed unit is acknowledged exactly once. The acknowledge is either a one-cycle hardware pulse or a single write of a chosen 32-bit value to a chosen register address over the same write port. The latched priority is presented on an output for an arbiter outside the block.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, `memRdEn`, `memWrEn`, `hwAck`, `blockDone` and `prioOut` are all 0. Requests that arrive before the first `start` cause no memory activity.
- R2: `start` latches every configuration input. `prioOut` shows the latched 2-bit priority (00 low, 01 medium, 10 high, 11 very high) and stays unchanged until the next `start`, whatever `prioIn` does.
- R3: A beat is a read cycle (`memRdEn` at the source pointer) followed in the next cycle by a write cycle (`memWrEn` at the destination pointer, carrying `memRdData` of that cycle). A read and a write never occur in the same cycle.
- R4: `cfgWord[1:0]` sets the source pointer mode and `cfgWord[3:2]` sets the destination pointer mode. 00 keeps the pointer fixed, 10 adds the step after each beat, 11 subtracts it, and 01 behaves as fixed.
- R5: `cfgWord[9:8]` sets the source step and `cfgWord[11:10]` sets the destination step: 00 is 1 byte, 01 is 2, 10 is 4, 11 is 8. The 16-bit block byte count drops by the destination step on every beat, or by what remains if that is less.
- R6: `cfgWord[29:28]`=00 (buffer mode). Each request moves `cfgWord[24:18]`+1 bytes, or fewer if the block runs out first. Once the block count reaches zero, the channel stops.
- R7: `cfgWord[29:28]`=01 (block mode). One request moves the whole block. The channel then stops, and later requests cause no memory activity until the next `start`.
- R8: `cfgWord[29:28]`=10 or 11. One request moves the whole block. The pointers and the count are then restored from the latched values, and the channel waits for the next request.
- R9: A request that arrives while a unit is in progress is remembered in one pending flag. It starts the next unit without any further request.
- R10: Each unit ends with exactly one acknowledge cycle. With `swAckEn`=0 this is a one-cycle `hwAck` pulse. With `swAckEn`=1 it is one write of `ackData`, zero-extended, to `ackAddr`. `blockDone` pulses in that same cycle when the block count has reached zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Latch the configuration and arm the channel |
| req | input | 1 | Peripheral request pulse |
| cfgWord | input | 32 | Pointer modes, steps, buffer length, trigger mode |
| blockLen | input | 16 | Block length in bytes (1 to 65535) |
| srcBase | input | 32 | Source start address |
| dstBase | input | 32 | Destination start address |
| prioIn | input | 2 | Channel priority to latch |
| swAckEn | input | 1 | 1 selects the register-write acknowledge |
| ackAddr | input | 32 | Register address for the acknowledge write |
| ackData | input | 32 | Value for the acknowledge write |
| memRdEn | output | 1 | Memory read strobe |
| memRdAddr | output | 32 | Memory read address |
| memRdData | input | 64 | Read data, valid one cycle after the read strobe |
| memWrEn | output | 1 | Memory write strobe |
| memWrAddr | output | 32 | Memory write address |
| memWrData | output | 64 | Memory write data |
| hwAck | output | 1 | Hardware acknowledge pulse |
| blockDone | output | 1 | Block count reached zero |
| prioOut | output | 2 | Latched priority for an external arbiter |

## Verification
The assertions assume the memory port returns read data exactly one cycle after a read strobe. They also assume `start` never lands in the middle of a beat, because a re-arm between the read and the write breaks the read-then-write pairing. The stimulus meets both assumptions:
- the bench memory is a register on the read address;
- `start` is pulsed only while the channel is idle or stopped;
- block lengths are always non-zero.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

  typedef enum logic [1:0] {
    TRIG_BUF    = 2'b00,
    TRIG_BLOCK  = 2'b01,
    TRIG_REPEAT = 2'b10,
    TRIG_LIST   = 2'b11
  } trig_e;

  typedef enum logic [2:0] {
    S_OFF, S_IDLE, S_RD, S_WR, S_ACK
  } chanState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // latch configuration, load pointers and count
    logic launch;    // begin a unit, load buffer counter
    logic beat;      // one beat finished, advance pointers and counters
    logic reload;    // restore pointers and count after a block
    logic rdPhase;
    logic wrPhase;
    logic ackPhase;
  } ctrlStrobes_t;

  // configuration word field positions
  localparam int SRC_MODE_LSB = 0;
  localparam int DST_MODE_LSB = 2;
  localparam int SRC_SZ_LSB   = 8;
  localparam int DST_SZ_LSB   = 10;
  localparam int BUF_LEN_LSB  = 18;
  localparam int BUF_LEN_W    = 7;
  localparam int TRIG_LSB     = 28;

  function automatic logic [3:0] stepBytes(input logic [1:0] sz);
    return 4'd1 << sz;
  endfunction

endpackage

// File: rtl/dmaseq_datapath.sv
module dmaseq_datapath
  import dmaseq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int CNT_W  = 16,
  parameter int ACK_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      stb,
  input  logic [31:0]       cfgWord,
  input  logic [CNT_W-1:0]  blockLen,
  input  logic [ADDR_W-1:0] srcBase,
  input  logic [ADDR_W-1:0] dstBase,
  input  logic [1:0]        prioIn,
  input  logic              swAckEn,
  input  logic [ADDR_W-1:0] ackAddr,
  input  logic [ACK_W-1:0]  ackData,
  input  logic [DATA_W-1:0] memRdData,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              hwAck,
  output logic              blockDone,
  output logic [1:0]        prioOut,
  output logic              lastBeat,
  output logic              blkZero,
  output trig_e             trigMode
);
  localparam int BUF_W = BUF_LEN_W + 1;

  logic [1:0]        srcModeQ, dstModeQ, srcSzQ, dstSzQ;
  logic [BUF_LEN_W-1:0] bufLenM1Q;
  trig_e             trigQ;
  logic [CNT_W-1:0]  blkLenQ, blkCnt;
  logic [ADDR_W-1:0] srcBaseQ, dstBaseQ, ackAddrQ, srcPtr, dstPtr;
  logic [ACK_W-1:0]  ackDataQ;
  logic              swAckQ;
  logic [1:0]        prioQ;
  logic [BUF_W-1:0]  bufCnt;

  function automatic logic [ADDR_W-1:0] advance(input logic [ADDR_W-1:0] a,
                                                input logic [1:0] mode,
                                                input logic [1:0] sz);
    case (mode)
      2'b10:   return a + ADDR_W'(stepBytes(sz));
      2'b11:   return a - ADDR_W'(stepBytes(sz));
      default: return a;  // 00 fixed, 01 reserved acts as fixed
    endcase
  endfunction

  logic [CNT_W-1:0] dstStepC, blkDec;
  logic [BUF_W-1:0] dstStepB, bufDec;

  always_comb begin
    dstStepC = CNT_W'(stepBytes(dstSzQ));
    dstStepB = BUF_W'(stepBytes(dstSzQ));
    blkDec   = (blkCnt < dstStepC) ? blkCnt : dstStepC;
    bufDec   = (bufCnt < dstStepB) ? bufCnt : dstStepB;
    lastBeat = (blkCnt <= dstStepC) || (trigQ == TRIG_BUF && bufCnt <= dstStepB);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcModeQ <= '0; dstModeQ <= '0; srcSzQ <= '0; dstSzQ <= '0;
      bufLenM1Q <= '0; trigQ <= TRIG_BUF; blkLenQ <= '0; blkCnt <= '0;
      srcBaseQ <= '0; dstBaseQ <= '0; ackAddrQ <= '0; ackDataQ <= '0;
      swAckQ <= 1'b0; prioQ <= '0; srcPtr <= '0; dstPtr <= '0; bufCnt <= '0;
    end else if (stb.load) begin
      srcModeQ  <= cfgWord[SRC_MODE_LSB +: 2];
      dstModeQ  <= cfgWord[DST_MODE_LSB +: 2];
      srcSzQ    <= cfgWord[SRC_SZ_LSB +: 2];
      dstSzQ    <= cfgWord[DST_SZ_LSB +: 2];
      bufLenM1Q <= cfgWord[BUF_LEN_LSB +: BUF_LEN_W];
      trigQ     <= trig_e'(cfgWord[TRIG_LSB +: 2]);
      blkLenQ   <= blockLen;
      blkCnt    <= blockLen;
      srcBaseQ  <= srcBase;
      dstBaseQ  <= dstBase;
      srcPtr    <= srcBase;
      dstPtr    <= dstBase;
      ackAddrQ  <= ackAddr;
      ackDataQ  <= ackData;
      swAckQ    <= swAckEn;
      prioQ     <= prioIn;
      bufCnt    <= '0;
    end else begin
      if (stb.launch) bufCnt <= BUF_W'(bufLenM1Q) + BUF_W'(1);
      if (stb.beat) begin
        srcPtr <= advance(srcPtr, srcModeQ, srcSzQ);
        dstPtr <= advance(dstPtr, dstModeQ, dstSzQ);
        blkCnt <= blkCnt - blkDec;
        bufCnt <= bufCnt - bufDec;
      end
      if (stb.reload) begin
        srcPtr <= srcBaseQ;
        dstPtr <= dstBaseQ;
        blkCnt <= blkLenQ;
      end
    end
  end

  assign blkZero   = (blkCnt == '0);
  assign trigMode  = trigQ;
  assign prioOut   = prioQ;
  assign memRdEn   = stb.rdPhase;
  assign memRdAddr = srcPtr;
  assign memWrEn   = stb.wrPhase | (stb.ackPhase & swAckQ);
  assign memWrAddr = stb.ackPhase ? ackAddrQ : dstPtr;
  assign memWrData = stb.ackPhase ? DATA_W'(ackDataQ) : memRdData;
  assign hwAck     = stb.ackPhase & ~swAckQ;
  assign blockDone = stb.ackPhase & blkZero;

endmodule

// File: rtl/dmaseq_ctrl.sv
module dmaseq_ctrl
  import dmaseq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         req,
  input  logic         lastBeat,
  input  logic         blkZero,
  input  trig_e        trigMode,
  output ctrlStrobes_t stb
);
  chanState_e state, nxt;
  logic       pending;

  always_comb begin
    nxt = state;
    stb = '0;
    case (state)
      S_OFF: nxt = S_OFF;
      S_IDLE: if (req || pending) begin
        stb.launch = 1'b1;
        nxt = S_RD;
      end
      S_RD: begin
        stb.rdPhase = 1'b1;
        nxt = S_WR;
      end
      S_WR: begin
        stb.wrPhase = 1'b1;
        stb.beat    = 1'b1;
        nxt = lastBeat ? S_ACK : S_RD;
      end
      S_ACK: begin
        stb.ackPhase = 1'b1;
        if (!blkZero) nxt = S_IDLE;
        else if (trigMode == TRIG_REPEAT || trigMode == TRIG_LIST) begin
          stb.reload = 1'b1;
          nxt = S_IDLE;
        end else nxt = S_OFF;
      end
      default: nxt = S_OFF;
    endcase
    if (start) begin
      stb.load   = 1'b1;
      stb.launch = 1'b0;
      stb.beat   = 1'b0;
      stb.reload = 1'b0;
      nxt = S_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_OFF;
      pending <= 1'b0;
    end else begin
      state <= nxt;
      if (start || stb.launch) pending <= 1'b0;
      else if (req && (state == S_RD || state == S_WR || state == S_ACK)) pending <= 1'b1;
    end
  end

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dmaseq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int CNT_W  = 16,
  parameter int ACK_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              req,
  input  logic [31:0]       cfgWord,
  input  logic [CNT_W-1:0]  blockLen,
  input  logic [ADDR_W-1:0] srcBase,
  input  logic [ADDR_W-1:0] dstBase,
  input  logic [1:0]        prioIn,
  input  logic              swAckEn,
  input  logic [ADDR_W-1:0] ackAddr,
  input  logic [ACK_W-1:0]  ackData,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              hwAck,
  output logic              blockDone,
  output logic [1:0]        prioOut
);
  ctrlStrobes_t stb;
  logic         lastBeat, blkZero;
  trig_e        trigMode;

  dmaseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .req(req),
    .lastBeat(lastBeat), .blkZero(blkZero), .trigMode(trigMode), .stb(stb)
  );

  dmaseq_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .ACK_W(ACK_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cfgWord(cfgWord), .blockLen(blockLen),
    .srcBase(srcBase), .dstBase(dstBase), .prioIn(prioIn), .swAckEn(swAckEn),
    .ackAddr(ackAddr), .ackData(ackData), .memRdData(memRdData),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memWrEn(memWrEn),
    .memWrAddr(memWrAddr), .memWrData(memWrData), .hwAck(hwAck),
    .blockDone(blockDone), .prioOut(prioOut), .lastBeat(lastBeat),
    .blkZero(blkZero), .trigMode(trigMode)
  );

endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       memRdEn,
  input logic       memWrEn,
  input logic       hwAck,
  input logic       blockDone,
  input logic [1:0] prioOut
);
  // R3
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdEn && memWrEn));

  // R3
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && !start) |=> memWrEn);

  // R10
  ack_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    hwAck |=> !hwAck);

  // R10
  hw_sw_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    hwAck |-> !memWrEn);

  // R10
  done_with_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    blockDone |-> (hwAck || memWrEn));

  // R2
  prio_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> $stable(prioOut));
endmodule

bind dma_chan_seq dma_chan_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .start(start), .memRdEn(memRdEn), .memWrEn(memWrEn),
  .hwAck(hwAck), .blockDone(blockDone), .prioOut(prioOut)
);

// File: tb/tb_dma_chan_seq.sv
`timescale 1ns/1ps
module tb_dma_chan_seq;
  localparam logic [31:0] SRC0 = 32'h0000_1000;
  localparam logic [31:0] DST0 = 32'h0000_8000;
  localparam logic [31:0] ACK_ADDR = 32'h4000_0010;
  localparam logic [31:0] ACK_VAL  = 32'h0000_00A5;

  // {cfgWord, blockLen, units, 7'b0, swAck}
  localparam int NVEC = 5;
  localparam logic [63:0] VEC [NVEC] = '{
    {32'h003C0A0A, 16'd40, 8'd3, 8'h00},  // buffer, inc/inc, 4B steps, 16B buffer
    {32'h1000040C, 16'd10, 8'd1, 8'h01},  // block, fixed/dec, 1B/2B, sw ack
    {32'h20000F0B, 16'd20, 8'd2, 8'h00},  // repeated, dec/inc, 8B steps
    {32'h30000005, 16'd3,  8'd2, 8'h01},  // list-as-repeat, reserved 01 both
    {32'h00000102, 16'd2,  8'd2, 8'h01}   // buffer of 1B, src 2B inc, dst fixed
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, start, req, swAckEn;
  logic [31:0] cfgWord, srcBase, dstBase, ackAddr, ackData;
  logic [15:0] blockLen;
  logic [1:0]  prioIn;
  logic        memRdEn, memWrEn, hwAck, blockDone;
  logic [31:0] memRdAddr, memWrAddr;
  logic [63:0] memRdData, memWrData;
  logic [1:0]  prioOut;

  dma_chan_seq dut (
    .clk(clk), .rstN(rstN), .start(start), .req(req), .cfgWord(cfgWord),
    .blockLen(blockLen), .srcBase(srcBase), .dstBase(dstBase), .prioIn(prioIn),
    .swAckEn(swAckEn), .ackAddr(ackAddr), .ackData(ackData),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .hwAck(hwAck), .blockDone(blockDone), .prioOut(prioOut)
  );

  // memory with one-cycle read latency; data tags the address read
  always_ff @(posedge clk) memRdData <= {~memRdAddr, memRdAddr};

  int checks = 0, fails = 0, cycles = 0;
  bit finished = 0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog act=%0d exp=<150000", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // bench model
  logic [31:0] expSrc, expDst;
  int expBlk, expBuf, blkLenM, bufLenM;
  logic [1:0] sMode, dMode, sSz, dSz, trig;
  bit swAckM;

  function automatic logic [31:0] nextAddr(input logic [31:0] a, input logic [1:0] m, input logic [1:0] sz);
    if (m == 2'b10) return a + (32'd1 << sz);
    if (m == 2'b11) return a - (32'd1 << sz);
    return a;
  endfunction

  task automatic setup(input logic [31:0] cfg, input int blk, input bit sw, input logic [1:0] prio);
    @(negedge clk);
    cfgWord = cfg; blockLen = 16'(blk); swAckEn = sw; prioIn = prio;
    srcBase = SRC0; dstBase = DST0; ackAddr = ACK_ADDR; ackData = ACK_VAL;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    sMode = cfg[1:0]; dMode = cfg[3:2]; sSz = cfg[9:8]; dSz = cfg[11:10];
    trig = cfg[29:28]; bufLenM = int'(cfg[24:18]) + 1; blkLenM = blk; swAckM = sw;
    expSrc = SRC0; expDst = DST0; expBlk = blk;
  endtask

  task automatic serveUnit(input bit pulseReq, input bit midReq);
    bit unitEnd = 0, ackSeen = 0;
    int step;
    expBuf = bufLenM;
    if (pulseReq) begin
      @(negedge clk); req = 1'b1;
      @(negedge clk); req = 1'b0;
    end
    for (int i = 0; i < 400 && !ackSeen; i++) begin
      @(negedge clk);
      req = (midReq && i == 2);
      if (memWrEn && !unitEnd) begin
        check(memWrAddr == expDst, "R3/R4 dst address", 64'(memWrAddr), 64'(expDst));
        check(memWrData == {~expSrc, expSrc}, "R3/R4 data from src", memWrData, {~expSrc, expSrc});
        step = 1 << dSz;
        expBlk -= (expBlk < step) ? expBlk : step;   // R5
        if (trig == 2'b00) expBuf -= (expBuf < step) ? expBuf : step;
        expSrc = nextAddr(expSrc, sMode, sSz);
        expDst = nextAddr(expDst, dMode, dSz);
        unitEnd = (expBlk == 0) || (trig == 2'b00 && expBuf == 0);
      end else if (unitEnd && (memWrEn || hwAck)) begin
        ackSeen = 1;
        if (swAckM)
          check(memWrEn && !hwAck && memWrAddr == ACK_ADDR && memWrData == {32'h0, ACK_VAL},
                "R10 sw ack write", memWrData, {32'h0, ACK_VAL});
        else
          check(hwAck && !memWrEn, "R10 hw ack pulse", {62'h0, hwAck, memWrEn}, 64'h2);
        check(blockDone == (expBlk == 0), "R10 blockDone", 64'(blockDone), 64'(expBlk == 0));
      end else if (hwAck || blockDone) begin
        check(0, "R10 ack before unit end", {62'h0, hwAck, blockDone}, 64'h0);
      end
    end
    req = 1'b0;
    check(ackSeen, "R6/R10 unit acknowledged", 64'(ackSeen), 64'h1);
    @(negedge clk);
    check(!hwAck && !blockDone && !memWrEn, "R10 single ack", {61'h0, hwAck, blockDone, memWrEn}, 64'h0);
    if (expBlk == 0 && trig[1]) begin  // R8 reload
      expSrc = SRC0; expDst = DST0; expBlk = blkLenM;
    end
  endtask

  task automatic expectQuiet(input string tag);
    bit busy = 0;
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (memRdEn || memWrEn || hwAck) busy = 1;
    end
    check(!busy, tag, 64'(busy), 64'h0);
  endtask

  initial begin
    rstN = 1'b0; start = 1'b0; req = 1'b0; cfgWord = '0; blockLen = '0;
    srcBase = '0; dstBase = '0; prioIn = 2'b11; swAckEn = 1'b0; ackAddr = '0; ackData = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!memRdEn && !memWrEn && !hwAck && !blockDone && prioOut == 2'b00, "R1 reset outputs",
          {59'h0, memRdEn, memWrEn, hwAck, blockDone, |prioOut}, 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    expectQuiet("R1 request before start ignored");

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      setup(VEC[v][63:32], int'(VEC[v][31:16]), VEC[v][0], 2'(v));
      for (int u = 0; u < int'(VEC[v][15:8]); u++) serveUnit(1, 0);
      if (VEC[v][61:60] == 2'b01) expectQuiet("R7 block mode stopped");
      else if (VEC[v][61:60] == 2'b00) expectQuiet("R6 buffer mode stopped after block");
    end

    // R2 priority latch, R9 pending request
    setup(32'h000C000A, 8, 0, 2'b10);
    prioIn = 2'b01;
    @(negedge clk);
    check(prioOut == 2'b10, "R2 prioOut latched", 64'(prioOut), 64'h2);
    serveUnit(1, 1);
    serveUnit(0, 0);
    check(expBlk == 0, "R9 pending served whole block", 64'(expBlk), 64'h0);
    expectQuiet("R6 stopped after pending unit");

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule